// File: doc/BRIEF.md
# Page Lock and Password Guard

This block sits behind a command decoder and in front of a small store of ten 32-bit pages. Pages 0 to 7 hold user data, page 8 holds the lock byte and the configuration bits, and page 9 holds the password. The decoder hands over one request at a time: read page, write page, write lock byte, write configuration, set password, check password or disable. The guard decides whether the request is allowed. If it is, the guard updates the store and returns the page that the reply frame should echo. If it is not, the guard raises an abort pulse and leaves the store untouched.

The protection rules work together. User lock bits can only be set. A lock write needs an earlier successful page write in the same reset period. A configuration lock freezes the configuration and the password lock. When the password mode is on, the password gates every page access until a check request matches. A disable request silences the block until reset. Stored contents reset to parameter values, which stand in for nonvolatile state.

The control path is a three-state machine. `ST_IDLE` waits for a request and moves to `ST_EVAL` when `req_valid` is high. `ST_EVAL` evaluates the captured request for one cycle, writes the store and registers the reply. From there it returns to `ST_IDLE`, or goes to `ST_HALT` after an accepted disable. `ST_HALT` holds until reset.

Top module: `pg_guard`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_ok`, `rsp_abort` and `rsp_echo` are 0. A request presented while `req_ready` is high gets exactly one one-cycle pulse on either `rsp_ok` or `rsp_abort`, visible after the second rising edge that follows the request edge.
- R2: Read page (op 0) of pages 0 to 8 and write page (op 1) of pages 0 to 7 are accepted with `rsp_echo`=1, `rsp_page` set to the page and `rsp_data` set to its contents. For a write, those contents are the new data.
- R3: Bit i of page 8 (i from 0 to 7) locks user page i. A write page to a locked page is refused, even when the password latch is set.
- R4: A lock write (op 2) takes its new lock bits from bits 7:0 of the data and requires 0xAA in each of bytes 1 to 3. The lock byte becomes the old byte ORed with the new bits, so no lock bit is ever cleared. The echo is page 8.
- R5: A lock write is refused unless a write page has been accepted since reset.
- R6: A config write (op 3) requires 0xAA in data byte 0 and replaces bits 31:8 of page 8 with data bits 31:8. The lock byte is left as it was. Bit 8 is the config lock, bit 9 is the password lock and bit 10 is the password mode. While bit 8 is 1, config writes are refused. The echo is page 8.
- R7: Set password (op 4) writes page 9 and replies with `rsp_ok` and no echo. It is refused while the password lock is 1.
- R8: While the password mode is 1 and the latch is clear, read, write, lock, config and set password requests are refused. A check password (op 5) whose data equals page 9 sets the latch until reset and replies with `rsp_ok` and no echo.
- R9: A check password with the wrong value is refused and leaves the latch clear.
- R10: No reply ever carries page 9. Read of page 9 and write page to pages 8 and 9 or above are refused.
- R11: A refused request, including op 7, raises `rsp_abort` and leaves every stored bit unchanged.
- R12: Disable (op 6) replies with `rsp_ok`. After that the block gives no reply to any request until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, restores stored defaults |
| req_valid | input | 1 | request present |
| req_op | input | 3 | request code |
| req_page | input | 4 | page number |
| req_data | input | 32 | request payload |
| req_ready | output | 1 | guard can take a request |
| rsp_ok | output | 1 | request accepted (one-cycle pulse) |
| rsp_abort | output | 1 | request refused (one-cycle pulse) |
| rsp_echo | output | 1 | reply carries a page |
| rsp_page | output | 4 | echoed page number |
| rsp_data | output | 32 | echoed page contents |

## Verification
Most wrong internal state becomes visible in the next reply. A lock bit that is cleared or not set shows in the page-8 echo of the next lock or config write. It also shows when a write page to a locked page is accepted where an abort is expected. A wrong password latch or wrong write-before-lock flag turns the very next gated request into the opposite pulse, two edges after it is presented. Stuck halt state shows as a missing or extra pulse on the first request after a disable.

// File: rtl/pg_guard_pkg.sv
package pg_guard_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_LOCK    = 3'd2,
        OP_CONFIG  = 3'd3,
        OP_SETPW   = 3'd4,
        OP_CHECKPW = 3'd5,
        OP_HALT    = 3'd6,
        OP_RSVD    = 3'd7
    } guard_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_HALT = 2'd2
    } guard_state_e;

    localparam logic [7:0] FILL_BYTE     = 8'hAA;
    localparam int         CFG_LOCK_BIT  = 8;
    localparam int         PW_LOCK_BIT   = 9;
    localparam int         PW_ON_BIT     = 10;

endpackage

// File: rtl/pg_guard_store.sv
module pg_guard_store #(
    parameter int                N_PAGES  = 10,
    parameter int                PAGE_W   = 32,
    parameter int                ADDR_W   = 4,
    parameter int                CFG_IDX  = 8,
    parameter int                PW_IDX   = 9,
    parameter logic [PAGE_W-1:0] CFG_INIT = '0,
    parameter logic [PAGE_W-1:0] PW_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_page,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_page,
    output logic [PAGE_W-1:0] rd_data,
    output logic [PAGE_W-1:0] cfg_word,
    output logic [PAGE_W-1:0] pw_word
);

    logic [N_PAGES-1:0][PAGE_W-1:0] pages;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PAGES; i++) begin
                if (i == CFG_IDX)     pages[i] <= CFG_INIT;
                else if (i == PW_IDX) pages[i] <= PW_INIT;
                else                  pages[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_PAGES; i++) begin
                if (wr_page == ADDR_W'(i)) pages[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_PAGES; i++) begin
            if (rd_page == ADDR_W'(i)) rd_data = pages[i];
        end
    end

    assign cfg_word = pages[CFG_IDX];
    assign pw_word  = pages[PW_IDX];

endmodule

// File: rtl/pg_guard_policy.sv
module pg_guard_policy
    import pg_guard_pkg::*;
#(
    parameter int N_USER = 8,
    parameter int PAGE_W = 32,
    parameter int ADDR_W = 4
) (
    input  guard_op_e         op,
    input  logic [ADDR_W-1:0] page,
    input  logic [PAGE_W-1:0] data,
    input  logic [PAGE_W-1:0] cfg_word,
    input  logic [PAGE_W-1:0] pw_word,
    input  logic [PAGE_W-1:0] page_word,
    input  logic              latch,
    input  logic              wrote,
    output logic              allow,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_page,
    output logic [PAGE_W-1:0] wr_data,
    output logic              echo,
    output logic [ADDR_W-1:0] echo_page,
    output logic [PAGE_W-1:0] echo_word,
    output logic              set_latch,
    output logic              set_wrote,
    output logic              halt
);

    localparam int                      CFG_IDX = N_USER;
    localparam int                      PW_IDX  = N_USER + 1;
    localparam int                      N_FILL  = (PAGE_W / 8) - 1;
    localparam logic [PAGE_W-9:0]       FILL_HI = {N_FILL{FILL_BYTE}};

    logic [N_USER-1:0] lock_byte;
    logic              cfg_lock, pw_lock, pw_on, gate_ok, user_pg, page_locked;
    logic [PAGE_W-1:0] new_cfg;

    assign lock_byte = cfg_word[N_USER-1:0];
    assign cfg_lock  = cfg_word[CFG_LOCK_BIT];
    assign pw_lock   = cfg_word[PW_LOCK_BIT];
    assign pw_on     = cfg_word[PW_ON_BIT];
    assign gate_ok   = !pw_on || latch;
    assign user_pg   = page < ADDR_W'(N_USER);

    always_comb begin
        page_locked = 1'b0;
        for (int i = 0; i < N_USER; i++) begin
            if (page == ADDR_W'(i)) page_locked = lock_byte[i];
        end
    end

    always_comb begin
        allow     = 1'b0;
        wr_en     = 1'b0;
        wr_page   = page;
        wr_data   = data;
        echo      = 1'b0;
        echo_page = page;
        echo_word = page_word;
        set_latch = 1'b0;
        set_wrote = 1'b0;
        halt      = 1'b0;
        new_cfg   = cfg_word;
        unique case (op)
            OP_READ: begin
                allow = gate_ok && (page < ADDR_W'(PW_IDX));
                echo  = allow;
            end
            OP_WRITE: begin
                allow     = gate_ok && user_pg && !page_locked;
                wr_en     = allow;
                echo      = allow;
                echo_word = data;
                set_wrote = allow;
            end
            OP_LOCK: begin
                new_cfg   = cfg_word;
                new_cfg[N_USER-1:0] = lock_byte | data[N_USER-1:0];
                allow     = gate_ok && wrote && (data[PAGE_W-1:8] == FILL_HI);
                wr_en     = allow;
                wr_page   = ADDR_W'(CFG_IDX);
                wr_data   = new_cfg;
                echo      = allow;
                echo_page = ADDR_W'(CFG_IDX);
                echo_word = new_cfg;
            end
            OP_CONFIG: begin
                new_cfg   = {data[PAGE_W-1:8], cfg_word[7:0]};
                allow     = gate_ok && !cfg_lock && (data[7:0] == FILL_BYTE);
                wr_en     = allow;
                wr_page   = ADDR_W'(CFG_IDX);
                wr_data   = new_cfg;
                echo      = allow;
                echo_page = ADDR_W'(CFG_IDX);
                echo_word = new_cfg;
            end
            OP_SETPW: begin
                allow   = gate_ok && !pw_lock;
                wr_en   = allow;
                wr_page = ADDR_W'(PW_IDX);
            end
            OP_CHECKPW: begin
                allow     = (data == pw_word);
                set_latch = allow;
            end
            OP_HALT: begin
                allow = 1'b1;
                halt  = 1'b1;
            end
            default: begin
                allow = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pg_guard.sv
module pg_guard
    import pg_guard_pkg::*;
#(
    parameter int          N_USER   = 8,
    parameter int          PAGE_W   = 32,
    parameter logic [31:0] CFG_INIT = 32'h0000_0000,
    parameter logic [31:0] PW_INIT  = 32'h1234_5678
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [3:0]  req_page,
    input  logic [31:0] req_data,
    output logic        req_ready,
    output logic        rsp_ok,
    output logic        rsp_abort,
    output logic        rsp_echo,
    output logic [3:0]  rsp_page,
    output logic [31:0] rsp_data
);

    localparam int N_PAGES = N_USER + 2;
    localparam int CFG_IDX = N_USER;
    localparam int PW_IDX  = N_USER + 1;
    localparam int ADDR_W  = 4;

    guard_state_e      state, state_nx;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] page_q;
    logic [PAGE_W-1:0] data_q;
    logic              latch, wrote;

    logic [PAGE_W-1:0] cfg_word, pw_word, page_word;
    logic              p_allow, p_wr_en, p_echo, p_set_latch, p_set_wrote, p_halt;
    logic [ADDR_W-1:0] p_wr_page, p_echo_page;
    logic [PAGE_W-1:0] p_wr_data, p_echo_word;
    logic              eval, st_wr_en;

    assign eval      = (state == ST_EVAL);
    assign st_wr_en  = eval && p_wr_en;
    assign req_ready = (state == ST_IDLE);

    pg_guard_policy #(.N_USER(N_USER), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_policy (
        .op        (guard_op_e'(op_q)),
        .page      (page_q),
        .data      (data_q),
        .cfg_word  (cfg_word),
        .pw_word   (pw_word),
        .page_word (page_word),
        .latch     (latch),
        .wrote     (wrote),
        .allow     (p_allow),
        .wr_en     (p_wr_en),
        .wr_page   (p_wr_page),
        .wr_data   (p_wr_data),
        .echo      (p_echo),
        .echo_page (p_echo_page),
        .echo_word (p_echo_word),
        .set_latch (p_set_latch),
        .set_wrote (p_set_wrote),
        .halt      (p_halt)
    );

    pg_guard_store #(
        .N_PAGES(N_PAGES), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W),
        .CFG_IDX(CFG_IDX), .PW_IDX(PW_IDX),
        .CFG_INIT(CFG_INIT), .PW_INIT(PW_INIT)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr_en),
        .wr_page  (p_wr_page),
        .wr_data  (p_wr_data),
        .rd_page  (page_q),
        .rd_data  (page_word),
        .cfg_word (cfg_word),
        .pw_word  (pw_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_EVAL;
            ST_EVAL: state_nx = (p_allow && p_halt) ? ST_HALT : ST_IDLE;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture and session flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            page_q <= '0;
            data_q <= '0;
            latch  <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                op_q   <= req_op;
                page_q <= req_page;
                data_q <= req_data;
            end
            if (eval && p_set_latch) latch <= 1'b1;
            if (eval && p_set_wrote) wrote <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_ok    <= 1'b0;
            rsp_abort <= 1'b0;
            rsp_echo  <= 1'b0;
            rsp_page  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_ok    <= eval && p_allow;
            rsp_abort <= eval && !p_allow;
            rsp_echo  <= eval && p_echo;
            rsp_page  <= (eval && p_echo) ? p_echo_page : '0;
            rsp_data  <= (eval && p_echo) ? p_echo_word : '0;
        end
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok || rsp_abort) |=> !(rsp_ok || rsp_abort));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_abort));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |=> (($past(cfg_word[N_USER-1:0]) & ~cfg_word[N_USER-1:0]) == '0));

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[CFG_LOCK_BIT] |=> (cfg_word[PAGE_W-1:8] == $past(cfg_word[PAGE_W-1:8])));

    a_r10_no_pw_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_echo |-> (rsp_page != ADDR_W'(PW_IDX)));

    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> latch);

    a_r12_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_HALT) |-> !(rsp_ok || rsp_abort));

    a_r11_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !p_allow) |=> ($stable(cfg_word) && $stable(pw_word)));

endmodule

// File: tb/pg_guard_tb.sv
module pg_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [3:0]  req_page = '0;
    logic [31:0] req_data = '0;
    logic        req_ready, rsp_ok, rsp_abort, rsp_echo;
    logic [3:0]  rsp_page;
    logic [31:0] rsp_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        bit          ok;
        bit          echo;
        logic [3:0]  page;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    pg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .req_data(req_data), .req_ready(req_ready),
        .rsp_ok(rsp_ok), .rsp_abort(rsp_abort), .rsp_echo(rsp_echo),
        .rsp_page(rsp_page), .rsp_data(rsp_data)
    );

    // monitor
    always @(negedge clk) begin
        if (rst_n && (rsp_ok || rsp_abort)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected reply ok=%0b abort=%0b, expected none", rsp_ok, rsp_abort);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_ok != e.ok || rsp_abort == e.ok || rsp_echo != e.echo ||
                    (e.echo && (rsp_page != e.page || rsp_data != e.data))) begin
                    errors++;
                    $display("FAIL %s: ok=%0b echo=%0b page=%0d data=%h, expected ok=%0b echo=%0b page=%0d data=%h",
                             e.tag, rsp_ok, rsp_echo, rsp_page, rsp_data, e.ok, e.echo, e.page, e.data);
                end
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [3:0] pg, input logic [31:0] d,
                        input bit ok, input bit echo, input logic [3:0] epg,
                        input logic [31:0] ed, input string tag);
        exp_t e;
        e.ok = ok; e.echo = echo; e.page = epg; e.data = ed; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_page = pg; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!req_ready || rsp_ok || rsp_abort || rsp_echo) begin
            errors++;
            $display("FAIL R1: ready=%0b ok=%0b abort=%0b echo=%0b, expected 1 0 0 0",
                     req_ready, rsp_ok, rsp_abort, rsp_echo);
        end

        send(3'd0, 4'd3, 32'h0, 1, 1, 4'd3, 32'h0, "R2 read fresh page");
        send(3'd2, 4'd0, 32'hAAAAAA01, 0, 0, 0, 0, "R5 lock before write");
        send(3'd1, 4'd2, 32'hDEADBEEF, 1, 1, 4'd2, 32'hDEADBEEF, "R2 write page");
        send(3'd0, 4'd2, 32'h0, 1, 1, 4'd2, 32'hDEADBEEF, "R2 read back");
        send(3'd2, 4'd0, 32'hAAAB_AA04, 0, 0, 0, 0, "R4 bad filler");
        send(3'd0, 4'd8, 32'h0, 1, 1, 4'd8, 32'h0, "R11 bad filler left lock byte");
        send(3'd2, 4'd0, 32'hAAAAAA04, 1, 1, 4'd8, 32'h00000004, "R4 lock page 2");
        send(3'd1, 4'd2, 32'h11111111, 0, 0, 0, 0, "R3 write locked page");
        send(3'd0, 4'd2, 32'h0, 1, 1, 4'd2, 32'hDEADBEEF, "R11 locked page unchanged");
        send(3'd2, 4'd0, 32'hAAAAAA01, 1, 1, 4'd8, 32'h00000005, "R4 OR in page 0");
        send(3'd2, 4'd0, 32'hAAAAAA00, 1, 1, 4'd8, 32'h00000005, "R4 zero never clears");
        send(3'd0, 4'd9, 32'h0, 0, 0, 0, 0, "R10 read password page");
        send(3'd1, 4'd8, 32'h0, 0, 0, 0, 0, "R10 write page 8");
        send(3'd7, 4'd0, 32'h0, 0, 0, 0, 0, "R11 reserved op");
        send(3'd3, 4'd0, 32'h000004AB, 0, 0, 0, 0, "R6 bad config filler");
        send(3'd3, 4'd0, 32'h000004AA, 1, 1, 4'd8, 32'h00000405, "R6 enable password mode");
        send(3'd0, 4'd2, 32'h0, 0, 0, 0, 0, "R8 read gated");
        send(3'd4, 4'd0, 32'hCAFEF00D, 0, 0, 0, 0, "R8 set password gated");
        send(3'd5, 4'd0, 32'h00000001, 0, 0, 0, 0, "R9 wrong password");
        send(3'd0, 4'd2, 32'h0, 0, 0, 0, 0, "R9 latch still clear");
        send(3'd5, 4'd0, 32'h12345678, 1, 0, 0, 0, "R8 right password");
        send(3'd0, 4'd2, 32'h0, 1, 1, 4'd2, 32'hDEADBEEF, "R8 read after latch");
        send(3'd1, 4'd2, 32'h22222222, 0, 0, 0, 0, "R3 locked despite latch");
        send(3'd4, 4'd0, 32'hCAFEF00D, 1, 0, 0, 0, "R7 set password");
        send(3'd5, 4'd0, 32'h12345678, 0, 0, 0, 0, "R7 old password rejected");
        send(3'd5, 4'd0, 32'hCAFEF00D, 1, 0, 0, 0, "R7 new password accepted");
        send(3'd3, 4'd0, 32'h000006AA, 1, 1, 4'd8, 32'h00000605, "R6 set password lock");
        send(3'd4, 4'd0, 32'h0BADF00D, 0, 0, 0, 0, "R7 password locked");
        send(3'd3, 4'd0, 32'h000007AA, 1, 1, 4'd8, 32'h00000705, "R6 set config lock");
        send(3'd3, 4'd0, 32'h000000AA, 0, 0, 0, 0, "R6 config locked");
        send(3'd0, 4'd8, 32'h0, 1, 1, 4'd8, 32'h00000705, "R6 config unchanged");
        send(3'd2, 4'd0, 32'hAAAAAA80, 1, 1, 4'd8, 32'h00000785, "R4 lock after config lock");
        send(3'd6, 4'd0, 32'h0, 1, 0, 0, 0, "R12 disable");

        // R12: further requests get no reply; the monitor flags any pulse
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_page = 4'd0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        checks++;
        if (rsp_ok || rsp_abort) begin
            errors++;
            $display("FAIL R12: ok=%0b abort=%0b after disable, expected 0 0", rsp_ok, rsp_abort);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d replies missing, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule